// File: doc/BRIEF.md
# Bootstrap Precharge Gate Sequencer

This block drives the six gate-driver inputs of a three-phase half-bridge stage through a fixed pulse order. The order charges a high-side bootstrap supply before that high-side switch is ever commanded. For one phase it turns the low-side switch on for a charge interval. It then turns every output off for a dead interval, turns the high-side switch on for a command interval, and finally holds everything off for a cooldown. One start pulse runs either a single selected phase or all three phases in turn.

A readback path returns the actual levels at the gate-driver inputs. In every cycle the block compares them with the pattern it expects. It checks the exact pattern, the number of active outputs, and whether both switches of one leg are on together. Any disagreement stops the sequence, forces all outputs off, and latches a fault. A latched fault blocks further runs until reset. All pins are plain control and status signals. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `bootstrap_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, all six gate outputs, `done` and `fault` are 0.
- R2: A start accepted in single mode (`all_phases`=0) latches `phase_sel`, where 0 selects U, 1 selects V and 2 selects W. Bit 0 of `gate_hi`/`gate_lo` is U, bit 1 is V and bit 2 is W. From the cycle after the start, the low side of that phase is high for `charge_len` cycles. Then all outputs are off for `dead_len` cycles. Then the high side is high for `cmd_len` cycles. Then all outputs are off for a cooldown of `dead_len` cycles.
- R3: A start accepted with `all_phases`=1 runs the full R2 pattern for U, then for V, then for W, with no gap between one phase's cooldown and the next phase's charge.
- R4: In every cycle at most one of the six outputs is high. Exactly one is high in each charge or command cycle, and none is high in the dead, cooldown or idle cycles.
- R5: A length input of 0 gives a step of one cycle. Lengths are read at the start of each step.
- R6: `done` is high for exactly one cycle, in the first idle cycle after the last cooldown cycle, and all outputs are off in that cycle.
- R7: A start that arrives while a sequence is running is ignored. The running sequence continues unchanged and produces one `done`.
- R8: If the readback (`fb_hi`, `fb_lo`) differs from the expected pattern in a cycle, then from the next cycle all outputs are off and `fault` is 1. No `done` is produced for the aborted run.
- R9: A readback with both switches of one phase high sets `fault`, even while idle.
- R10: `fault` stays 1 until reset, and starts are ignored while it is set.
- R11: In single mode, a start with `phase_sel`=3 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start request, sampled when idle |
| all_phases | input | 1 | 1: run U, V, W in turn; 0: single phase |
| phase_sel | input | 2 | Phase for single mode (0 U, 1 V, 2 W) |
| charge_len | input | CNT_W | Low-side charge length in cycles (0 means 1) |
| dead_len | input | CNT_W | Dead and cooldown length in cycles (0 means 1) |
| cmd_len | input | CNT_W | High-side command length in cycles (0 means 1) |
| fb_hi | input | 3 | Readback of the high-side gate inputs |
| fb_lo | input | 3 | Readback of the low-side gate inputs |
| gate_hi | output | 3 | High-side gate drives, bit 0 U |
| gate_lo | output | 3 | Low-side gate drives, bit 0 U |
| done | output | 1 | One-cycle end-of-sequence pulse |
| fault | output | 1 | Sticky readback fault |

## Verification
Two collisions can happen in the same cycle. In the first, a new start lands on the cycle where `done` pulses. The bench raises `start` in exactly that cycle and expects the new run's charge step on the next cycle, because the block is idle by then. In the second, a readback fault lands on the final cooldown cycle. The bench injects a flipped readback bit in that cycle and expects `fault` set with no `done`, because an abort takes priority over completion.

// File: rtl/bootstrap_seq_pkg.sv
`timescale 1ns/1ps
package bootstrap_seq_pkg;
  localparam int unsigned NUM_PH = 3;
  localparam int unsigned PH_W   = 2;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_CHARGE = 3'd1,
    ST_DEAD   = 3'd2,
    ST_CMD    = 3'd3,
    ST_COOL   = 3'd4
  } step_e;
endpackage

// File: rtl/bootstrap_seq_timer.sv
`timescale 1ns/1ps
module bootstrap_seq_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] len,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      // a zero length behaves as one cycle (R5)
      cnt_q <= (len == '0) ? '0 : len - 1'b1;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/bootstrap_seq_decode.sv
`timescale 1ns/1ps
module bootstrap_seq_decode
  import bootstrap_seq_pkg::*;
(
  input  step_e             step,
  input  logic [PH_W-1:0]   phase,
  output logic [NUM_PH-1:0] hi,
  output logic [NUM_PH-1:0] lo,
  output logic [1:0]        active_cnt
);
  for (genvar g = 0; g < NUM_PH; g++) begin : g_leg
    assign lo[g] = (step == ST_CHARGE) && (phase == PH_W'(g));
    assign hi[g] = (step == ST_CMD)    && (phase == PH_W'(g));
  end

  assign active_cnt = ((step == ST_CHARGE) || (step == ST_CMD)) ? 2'd1 : 2'd0;
endmodule

// File: rtl/bootstrap_seq_monitor.sv
`timescale 1ns/1ps
module bootstrap_seq_monitor
  import bootstrap_seq_pkg::*;
(
  input  logic [NUM_PH-1:0] exp_hi,
  input  logic [NUM_PH-1:0] exp_lo,
  input  logic [1:0]        exp_cnt,
  input  logic [NUM_PH-1:0] fb_hi,
  input  logic [NUM_PH-1:0] fb_lo,
  output logic              mismatch
);
  logic       pattern_bad;
  logic       count_bad;
  logic       leg_overlap;
  logic [2:0] fb_cnt;

  always_comb begin
    fb_cnt = '0;
    for (int i = 0; i < NUM_PH; i++) begin
      fb_cnt = fb_cnt + {2'b00, fb_hi[i]} + {2'b00, fb_lo[i]};
    end
  end

  assign pattern_bad = (fb_hi != exp_hi) || (fb_lo != exp_lo);
  assign count_bad   = (fb_cnt != {1'b0, exp_cnt});
  assign leg_overlap = |(fb_hi & fb_lo);
  assign mismatch    = pattern_bad || count_bad || leg_overlap;
endmodule

// File: rtl/bootstrap_seq.sv
`timescale 1ns/1ps
module bootstrap_seq
  import bootstrap_seq_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             all_phases,
  input  logic [1:0]       phase_sel,
  input  logic [CNT_W-1:0] charge_len,
  input  logic [CNT_W-1:0] dead_len,
  input  logic [CNT_W-1:0] cmd_len,
  input  logic [2:0]       fb_hi,
  input  logic [2:0]       fb_lo,
  output logic [2:0]       gate_hi,
  output logic [2:0]       gate_lo,
  output logic             done,
  output logic             fault
);
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(NUM_PH - 1);

  step_e           state_q, state_d;
  logic [PH_W-1:0] ph_q, ph_d;
  logic            all_q, all_d;
  logic            done_q, done_d;
  logic            fault_q, fault_d;
  logic            tmr_load, tmr_expired;
  logic [CNT_W-1:0] tmr_len;
  logic [2:0]      exp_hi, exp_lo;
  logic [1:0]      exp_cnt;
  logic            mismatch;

  bootstrap_seq_decode u_decode (
    .step       (state_q),
    .phase      (ph_q),
    .hi         (exp_hi),
    .lo         (exp_lo),
    .active_cnt (exp_cnt)
  );

  bootstrap_seq_monitor u_monitor (
    .exp_hi   (exp_hi),
    .exp_lo   (exp_lo),
    .exp_cnt  (exp_cnt),
    .fb_hi    (fb_hi),
    .fb_lo    (fb_lo),
    .mismatch (mismatch)
  );

  bootstrap_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .len     (tmr_len),
    .expired (tmr_expired)
  );

  always_comb begin
    state_d = state_q;
    ph_d    = ph_q;
    all_d   = all_q;
    done_d  = 1'b0;
    fault_d = fault_q;
    if (mismatch) begin
      // abort has priority over any step change or completion
      state_d = ST_IDLE;
      fault_d = 1'b1;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start && !fault_q && (all_phases || (phase_sel != 2'd3))) begin
            state_d = ST_CHARGE;
            all_d   = all_phases;
            ph_d    = all_phases ? '0 : phase_sel;
          end
        end
        ST_CHARGE: if (tmr_expired) state_d = ST_DEAD;
        ST_DEAD:   if (tmr_expired) state_d = ST_CMD;
        ST_CMD:    if (tmr_expired) state_d = ST_COOL;
        ST_COOL: begin
          if (tmr_expired) begin
            if (all_q && (ph_q != LAST_PH)) begin
              ph_d    = ph_q + 1'b1;
              state_d = ST_CHARGE;
            end else begin
              state_d = ST_IDLE;
              done_d  = 1'b1;
            end
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  assign tmr_load = (state_d != state_q);

  always_comb begin
    case (state_d)
      ST_CHARGE: tmr_len = charge_len;
      ST_CMD:    tmr_len = cmd_len;
      default:   tmr_len = dead_len;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ph_q    <= '0;
      all_q   <= 1'b0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      state_q <= state_d;
      ph_q    <= ph_d;
      all_q   <= all_d;
      done_q  <= done_d;
      fault_q <= fault_d;
    end
  end

  assign gate_hi = exp_hi;
  assign gate_lo = exp_lo;
  assign done    = done_q;
  assign fault   = fault_q;
endmodule

// File: rtl/bootstrap_seq_chk.sv
`timescale 1ns/1ps
module bootstrap_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] gate_hi,
  input logic [2:0] gate_lo,
  input logic       done,
  input logic       fault
);
  assert_one_active_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({gate_hi, gate_lo}));

  assert_dead_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((|gate_hi) && !$past(|gate_hi)) |-> ($past(gate_lo) == 3'b000));

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((gate_hi == 3'b000) && (gate_lo == 3'b000)));

  assert_abort_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> ((gate_hi == 3'b000) && (gate_lo == 3'b000)));

  assert_fault_no_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !done);

  assert_fault_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> fault);
endmodule

bind bootstrap_seq bootstrap_seq_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .gate_hi (gate_hi),
  .gate_lo (gate_lo),
  .done    (done),
  .fault   (fault)
);

// File: tb/bootstrap_seq_tb_top.sv
`timescale 1ns/1ps
module bootstrap_seq_tb_top;
  localparam int CNT_W = 8;

  // vector fields: all(1) sel(2) charge(8) dead(8) cmd(8)
  localparam int NVEC = 5;
  localparam logic [26:0] VECS [NVEC] = '{
    {1'b0, 2'd0, 8'd3, 8'd2, 8'd4},
    {1'b0, 2'd1, 8'd1, 8'd1, 8'd1},
    {1'b0, 2'd2, 8'd0, 8'd0, 8'd0},
    {1'b1, 2'd0, 8'd2, 8'd1, 8'd3},
    {1'b1, 2'd1, 8'd0, 8'd3, 8'd0}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic             all_i = 1'b0;
  logic [1:0]       sel_i = 2'd0;
  logic [CNT_W-1:0] c_len = 8'd1;
  logic [CNT_W-1:0] d_len = 8'd1;
  logic [CNT_W-1:0] m_len = 8'd1;
  logic [2:0]       inj_hi = 3'b000;
  logic [2:0]       inj_lo = 3'b000;
  logic [2:0]       gate_hi, gate_lo, fb_hi, fb_lo;
  logic             done, fault;

  int  checks = 0;
  int  fails = 0;
  int  cyc_idx = 0;
  int  restart_idx = -1;
  logic       r_all = 1'b0;
  logic [1:0] r_sel = 2'd0;
  bit  finished = 1'b0;

  always #4 clk = ~clk;

  assign fb_hi = gate_hi ^ inj_hi;
  assign fb_lo = gate_lo ^ inj_lo;

  bootstrap_seq #(.CNT_W(CNT_W)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .all_phases (all_i),
    .phase_sel  (sel_i),
    .charge_len (c_len),
    .dead_len   (d_len),
    .cmd_len    (m_len),
    .fb_hi      (fb_hi),
    .fb_lo      (fb_lo),
    .gate_hi    (gate_hi),
    .gate_lo    (gate_lo),
    .done       (done),
    .fault      (fault)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic chk_outs(input logic [2:0] eh, input logic [2:0] el,
                          input logic ed, input logic ef, input string rq);
    chk({gate_hi, gate_lo, done, fault} == {eh, el, ed, ef}, rq, "hi/lo/done/fault",
        {24'd0, gate_hi, gate_lo, done, fault}, {24'd0, eh, el, ed, ef});
  endtask

  task automatic step_exp(input logic [2:0] eh, input logic [2:0] el,
                          input logic ed, input string rq);
    if (cyc_idx == restart_idx) begin
      all_i = r_all;
      sel_i = r_sel;
      start = 1'b1;
    end else begin
      start = 1'b0;
    end
    chk_outs(eh, el, ed, 1'b0, rq);
    cyc_idx++;
    @(negedge clk);
  endtask

  task automatic issue_start(input logic a, input logic [1:0] s,
                             input int c, input int d, input int m);
    @(negedge clk);
    all_i = a; sel_i = s;
    c_len = CNT_W'(c); d_len = CNT_W'(d); m_len = CNT_W'(m);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // expected run from the requirements, starting at the first charge cycle
  task automatic check_body(input bit a, input int s, input int c, input int d,
                            input int m, input string rq);
    int ec = (c == 0) ? 1 : c;
    int ed = (d == 0) ? 1 : d;
    int em = (m == 0) ? 1 : m;
    int first = a ? 0 : s;
    int last  = a ? 2 : s;
    for (int p = first; p <= last; p++) begin
      for (int k = 0; k < ec; k++) step_exp(3'b000, 3'(1 << p), 1'b0, rq);
      for (int k = 0; k < ed; k++) step_exp(3'b000, 3'b000, 1'b0, rq);
      for (int k = 0; k < em; k++) step_exp(3'(1 << p), 3'b000, 1'b0, rq);
      for (int k = 0; k < ed; k++) step_exp(3'b000, 3'b000, 1'b0, rq);
    end
    step_exp(3'b000, 3'b000, 1'b1, {rq, " R6"});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; start = 1'b0; inj_hi = '0; inj_lo = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #1600000;
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    chk_outs(3'b000, 3'b000, 1'b0, 1'b0, "R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk_outs(3'b000, 3'b000, 1'b0, 1'b0, "R1 after reset");

    // vector table: R2, R3, R4, R5, R6
    for (int v = 0; v < NVEC; v++) begin
      logic [26:0] vec = VECS[v];
      int c = int'(vec[23:16]);
      int d = int'(vec[15:8]);
      int m = int'(vec[7:0]);
      string rq = (c == 0 || d == 0 || m == 0) ? "R5 R4" : (vec[26] ? "R3 R4" : "R2 R4");
      issue_start(vec[26], vec[25:24], c, d, m);
      cyc_idx = 0; restart_idx = -1;
      check_body(vec[26], int'(vec[25:24]), c, d, m, rq);
      start = 1'b0;
      chk_outs(3'b000, 3'b000, 1'b0, 1'b0, "R6 idle after done");
      @(negedge clk);
    end

    // R7: start during a run is ignored
    issue_start(1'b0, 2'd0, 5, 2, 3);
    cyc_idx = 0; restart_idx = 2; r_all = 1'b1; r_sel = 2'd2;
    check_body(1'b0, 0, 5, 2, 3, "R7");
    start = 1'b0; restart_idx = -1;
    for (int k = 0; k < 4; k++) begin
      chk_outs(3'b000, 3'b000, 1'b0, 1'b0, "R7 no second run");
      @(negedge clk);
    end

    // collision: start in the done cycle launches a new run
    issue_start(1'b0, 2'd2, 2, 1, 1);
    cyc_idx = 0; restart_idx = 5; r_all = 1'b1; r_sel = 2'd0;
    check_body(1'b0, 2, 2, 1, 1, "R6 R2");
    start = 1'b0; restart_idx = -1; cyc_idx = 0;
    check_body(1'b1, 0, 2, 1, 1, "R6 R3 restart");
    start = 1'b0;

    // R11: phase_sel 3 in single mode is ignored
    issue_start(1'b0, 2'd3, 1, 1, 1);
    for (int k = 0; k < 8; k++) begin
      chk_outs(3'b000, 3'b000, 1'b0, 1'b0, "R11");
      @(negedge clk);
    end

    // R8: mismatch in command step of phase V
    issue_start(1'b0, 2'd1, 4, 2, 4);
    repeat (7) @(negedge clk);
    chk_outs(3'b010, 3'b000, 1'b0, 1'b0, "R2 pre-fault command");
    inj_lo = 3'b001;
    @(negedge clk);
    inj_lo = 3'b000;
    chk_outs(3'b000, 3'b000, 1'b0, 1'b1, "R8 abort");
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      chk_outs(3'b000, 3'b000, 1'b0, 1'b1, "R8 stays off no done");
    end
    // R10: start ignored while fault set
    start = 1'b1; all_i = 1'b0; sel_i = 2'd0;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 6; k++) begin
      chk_outs(3'b000, 3'b000, 1'b0, 1'b1, "R10 locked");
      @(negedge clk);
    end
    do_reset();
    chk_outs(3'b000, 3'b000, 1'b0, 1'b0, "R10 cleared by reset");

    // R9: leg overlap on readback while idle
    inj_hi = 3'b100; inj_lo = 3'b100;
    @(negedge clk);
    inj_hi = 3'b000; inj_lo = 3'b000;
    chk_outs(3'b000, 3'b000, 1'b0, 1'b1, "R9 overlap idle");
    do_reset();

    // collision: fault on the final cooldown cycle beats done
    issue_start(1'b0, 2'd0, 1, 2, 1);
    repeat (5) @(negedge clk);
    chk_outs(3'b000, 3'b000, 1'b0, 1'b0, "R2 last cooldown");
    inj_hi = 3'b001;
    @(negedge clk);
    inj_hi = 3'b000;
    chk_outs(3'b000, 3'b000, 1'b0, 1'b1, "R8 abort over done");
    @(negedge clk);
    chk_outs(3'b000, 3'b000, 1'b0, 1'b1, "R8 no late done");
    do_reset();

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule